// File: doc/BRIEF.md
# Scatter-gather stream-to-memory engine

This block moves packets arriving on a 32-bit streaming input into memory, using a linked list of descriptors held in that same memory. For each descriptor it fetches four header words (next pointer, buffer address, control, status). It fills the buffer one word per beat until the descriptor's capacity is used up or the packet ends. It then writes a status word back and follows the next pointer. A separate control stream carries five application words. The engine latches them and copies them into the last descriptor of each packet.

The register block outside this engine supplies several signals:
- the run level;
- a start pulse that clears the halted and idle conditions;
- a tail-write pulse that clears idle;
- a load strobe with a value for the current pointer;
- the tail pointer.

The engine returns:
- the current pointer;
- a halted level;
- an idle level;
- a one-cycle completion pulse per packet;
- a one-cycle error pulse for a control stream of the wrong length.

Memory traffic uses a simple word port. A request stays asserted with a stable address and data until it is acknowledged. Read data arrives together with the acknowledge.

The state machine has seven states:
- WAIT: a packet may start when running, not idle and data is valid (go).
- FETCH: four header reads.
- CHECK: inspects the fetched status.
- TAKE: accepts one beat.
- STORE: writes the beat to the buffer.
- APPEND: writes the application words.
- CLOSE: writes the status word.

The transitions are:
- WAIT→FETCH on go.
- FETCH→CHECK after the fourth read.
- CHECK→WAIT if the descriptor is already complete (halt).
- CHECK→CLOSE if the capacity is below one word.
- CHECK→TAKE otherwise.
- TAKE→STORE on a beat handshake.
- STORE→APPEND on the last beat.
- STORE→CLOSE when no further word fits.
- STORE→TAKE otherwise.
- APPEND→CLOSE after the fifth word.
- CLOSE→WAIT at packet end or when the finished descriptor was the tail.
- CLOSE→FETCH otherwise (the packet continues).

Top module: `s2mm_sg_engine`

## Requirements
- R1: A descriptor is nine words at byte offsets 0 (next pointer), 4 (buffer address), 8 (control), 12 (status) and 16..32 (application words). Control bits 22:0 give the buffer capacity in bytes. The low two bits of the capacity are ignored, and control bits above 22 have no effect. Beats are written to consecutive words of the buffer. A descriptor is closed when the next word would not fit, or earlier when the packet ends.
- R2: A fetched descriptor whose status bit 31 is already set makes halted go high. No data is accepted, nothing is written, and halted stays high until a start pulse.
- R3: Status bit 27 is set only in the first descriptor used for a packet.
- R4: Status bit 26 is set only in the descriptor that received the packet's last beat, and exactly one completion pulse is given per packet.
- R5: The five most recently latched application words are written to words 4..8 of the final descriptor of a packet; other descriptors' application words are not written.
- R6: Every descriptor used gets a status word with bit 31 set and the number of bytes written in bits 22:0.
- R7: After a descriptor is closed, the current pointer takes its next pointer. If the closed descriptor was the tail, idle goes high and the engine stops until a tail-write or start pulse.
- R8: A control-stream packet of other than five words produces an error pulse and leaves the latched application words unchanged.
- R9: The data input is not ready while run is low, or while halted or idle is high.
- R10: After reset, halted is high, idle is low, the current pointer is zero, and no request, ready or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Channel run level |
| start_i | input | 1 | Clears halted and idle |
| tail_wr_i | input | 1 | Tail pointer was written; clears idle |
| cur_load_i | input | 1 | Load current pointer |
| cur_ptr_i | input | ADDR_W | Value for current pointer |
| tail_ptr_i | input | ADDR_W | Tail descriptor address |
| dat_tvalid | input | 1 | Data stream valid |
| dat_tready | output | 1 | Data stream ready |
| dat_tdata | input | 32 | Data stream word |
| dat_tlast | input | 1 | Last beat of packet |
| ctl_tvalid | input | 1 | Control stream valid |
| ctl_tready | output | 1 | Control stream ready |
| ctl_tdata | input | 32 | Control stream word |
| ctl_tlast | input | 1 | Last control word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| cur_ptr_o | output | ADDR_W | Current descriptor pointer |
| halted_o | output | 1 | Halted level |
| idle_o | output | 1 | Idle level |
| done_o | output | 1 | Packet completion pulse |
| ctl_err_o | output | 1 | Control stream length error pulse |

## Verification
The bench aims at packets that end exactly on a full descriptor, one word short of it, and one word past it. A wrong room comparison would then leave an extra empty descriptor or overrun a buffer. It uses capacities with nonzero low bits and junk high control bits to catch a capacity that is not masked. It runs a packet across the tail descriptor to catch an engine that keeps walking past it. It feeds short and long control packets, which a design that commits words as they arrive would leak into the next descriptor. It also offers a descriptor that is already complete, where a faulty engine would overwrite the buffer or accept a beat.

// File: rtl/s2mm_sg_pkg.sv
package s2mm_sg_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 23;   // byte count / capacity field
    localparam int BIT_CMPL = 31;
    localparam int BIT_SOF  = 27;
    localparam int BIT_EOF  = 26;

    // word offsets inside a descriptor
    localparam int OFS_NEXT = 0;
    localparam int OFS_BUF  = 1;
    localparam int OFS_CTRL = 2;
    localparam int OFS_STAT = 3;
    localparam int OFS_APP  = 4;
    localparam int HDR_WORDS = 4;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_FETCH,
        ST_CHECK,
        ST_TAKE,
        ST_STORE,
        ST_APPEND,
        ST_CLOSE
    } walk_state_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic             sof,
        input logic             eof,
        input logic [LEN_W-1:0] nbytes
    );
        logic [WORD_W-1:0] w;
        w              = '0;
        w[BIT_CMPL]    = 1'b1;
        w[BIT_SOF]     = sof;
        w[BIT_EOF]     = eof;
        w[LEN_W-1:0]   = nbytes;
        return w;
    endfunction

endpackage

// File: rtl/s2mm_app_capture.sv
module s2mm_app_capture
    import s2mm_sg_pkg::*;
#(
    parameter int APP_WORDS = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ctl_tvalid,
    output logic                            ctl_tready,
    input  logic [WORD_W-1:0]               ctl_tdata,
    input  logic                            ctl_tlast,
    output logic [APP_WORDS-1:0][WORD_W-1:0] app_o,
    output logic                            err_o
);

    localparam int CNT_W = $clog2(APP_WORDS + 1);

    logic [CNT_W-1:0]                cnt_q;
    logic [APP_WORDS-1:0][WORD_W-1:0] stage_q;

    assign ctl_tready = 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            stage_q <= '0;
            app_o   <= '0;
            err_o   <= 1'b0;
        end else begin
            err_o <= 1'b0;
            if (ctl_tvalid) begin
                for (int i = 0; i < APP_WORDS; i++) begin
                    if (cnt_q == CNT_W'(i)) begin
                        stage_q[i] <= ctl_tdata;
                    end
                end
                if (ctl_tlast) begin
                    cnt_q <= '0;
                    if (cnt_q == CNT_W'(APP_WORDS - 1)) begin
                        for (int i = 0; i < APP_WORDS; i++) begin
                            app_o[i] <= (i == APP_WORDS - 1) ? ctl_tdata : stage_q[i];
                        end
                    end else begin
                        err_o <= 1'b1;
                    end
                end else if (cnt_q != CNT_W'(APP_WORDS)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/s2mm_chan_state.sv
module s2mm_chan_state #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tail_wr_i,
    input  logic              cur_load_i,
    input  logic [ADDR_W-1:0] cur_val_i,
    input  logic              set_halt_i,
    input  logic              set_idle_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] adv_ptr_i,
    output logic              halted_o,
    output logic              idle_o,
    output logic [ADDR_W-1:0] cur_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_o <= 1'b1;
            idle_o   <= 1'b0;
            cur_o    <= '0;
        end else begin
            if (set_halt_i) begin
                halted_o <= 1'b1;
            end else if (start_i) begin
                halted_o <= 1'b0;
            end

            if (set_idle_i) begin
                idle_o <= 1'b1;
            end else if (start_i || tail_wr_i) begin
                idle_o <= 1'b0;
            end

            if (cur_load_i) begin
                cur_o <= cur_val_i;
            end else if (adv_i) begin
                cur_o <= adv_ptr_i;
            end
        end
    end

endmodule

// File: rtl/s2mm_sg_engine.sv
module s2mm_sg_engine
    import s2mm_sg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int APP_WORDS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              start_i,
    input  logic              tail_wr_i,
    input  logic              cur_load_i,
    input  logic [ADDR_W-1:0] cur_ptr_i,
    input  logic [ADDR_W-1:0] tail_ptr_i,
    input  logic              dat_tvalid,
    output logic              dat_tready,
    input  logic [31:0]       dat_tdata,
    input  logic              dat_tlast,
    input  logic              ctl_tvalid,
    output logic              ctl_tready,
    input  logic [31:0]       ctl_tdata,
    input  logic              ctl_tlast,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_ptr_o,
    output logic              halted_o,
    output logic              idle_o,
    output logic              done_o,
    output logic              ctl_err_o
);

    localparam int IDX_W = ($clog2(APP_WORDS) > 2) ? $clog2(APP_WORDS) : 2;
    localparam int BYTES_PER_BEAT = WORD_W / 8;
    localparam logic [LEN_W:0]      TWO_BEATS = (LEN_W + 1)'(2 * BYTES_PER_BEAT);
    localparam logic [IDX_W-1:0]    HDR_LAST  = IDX_W'(HDR_WORDS - 1);
    localparam logic [IDX_W-1:0]    APP_LAST  = IDX_W'(APP_WORDS - 1);

    walk_state_t st_q, st_d;

    logic [APP_WORDS-1:0][WORD_W-1:0] app_w;
    logic [ADDR_W-1:0] nxt_q, buf_q;
    logic [LEN_W-1:0]  cap_q, cnt_q;
    logic [LEN_W-1:0]  cap_eff;
    logic [WORD_W-1:0] beat_q;
    logic [WORD_W-1:0] app_sel;
    logic [IDX_W-1:0]  wi_q;
    logic              done_cmpl_q;
    logic              last_q, eof_q, open_q, done_q;
    logic              go, hs_beat, room_gone, at_tail;
    logic              set_halt, set_idle, adv;

    s2mm_app_capture #(.APP_WORDS(APP_WORDS)) u_app (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_tvalid (ctl_tvalid),
        .ctl_tready (ctl_tready),
        .ctl_tdata  (ctl_tdata),
        .ctl_tlast  (ctl_tlast),
        .app_o      (app_w),
        .err_o      (ctl_err_o)
    );

    s2mm_chan_state #(.ADDR_W(ADDR_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tail_wr_i  (tail_wr_i),
        .cur_load_i (cur_load_i),
        .cur_val_i  (cur_ptr_i),
        .set_halt_i (set_halt),
        .set_idle_i (set_idle),
        .adv_i      (adv),
        .adv_ptr_i  (nxt_q),
        .halted_o   (halted_o),
        .idle_o     (idle_o),
        .cur_o      (cur_ptr_o)
    );

    assign cap_eff   = {cap_q[LEN_W-1:2], 2'b00};
    assign go        = run_i && !halted_o && !idle_o && dat_tvalid;
    assign hs_beat   = dat_tvalid && dat_tready;
    assign room_gone = ({1'b0, cnt_q} + TWO_BEATS) > {1'b0, cap_eff};
    assign at_tail   = (cur_ptr_o == tail_ptr_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT:   if (go) st_d = ST_FETCH;
            ST_FETCH:  if (mem_ack && wi_q == HDR_LAST) st_d = ST_CHECK;
            ST_CHECK: begin
                if (done_cmpl_q)          st_d = ST_WAIT;
                else if (cap_eff == '0)   st_d = ST_CLOSE;
                else                      st_d = ST_TAKE;
            end
            ST_TAKE:   if (hs_beat) st_d = ST_STORE;
            ST_STORE: begin
                if (mem_ack) begin
                    if (last_q)         st_d = ST_APPEND;
                    else if (room_gone) st_d = ST_CLOSE;
                    else                st_d = ST_TAKE;
                end
            end
            ST_APPEND: if (mem_ack && wi_q == APP_LAST) st_d = ST_CLOSE;
            ST_CLOSE: begin
                if (mem_ack) begin
                    if (eof_q || at_tail) st_d = ST_WAIT;
                    else                  st_d = ST_FETCH;
                end
            end
            default:   st_d = ST_WAIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q       <= '0;
            buf_q       <= '0;
            cap_q       <= '0;
            cnt_q       <= '0;
            beat_q      <= '0;
            wi_q        <= '0;
            done_cmpl_q <= 1'b0;
            last_q      <= 1'b0;
            eof_q       <= 1'b0;
            open_q      <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_WAIT: begin
                    wi_q <= '0;
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        unique case (wi_q)
                            IDX_W'(OFS_NEXT): nxt_q <= ADDR_W'(mem_rdata);
                            IDX_W'(OFS_BUF):  buf_q <= ADDR_W'(mem_rdata);
                            IDX_W'(OFS_CTRL): cap_q <= mem_rdata[LEN_W-1:0];
                            default:          done_cmpl_q <= mem_rdata[BIT_CMPL];
                        endcase
                        wi_q <= (wi_q == HDR_LAST) ? '0 : wi_q + 1'b1;
                    end
                end
                ST_CHECK: begin
                    cnt_q  <= '0;
                    eof_q  <= 1'b0;
                    last_q <= 1'b0;
                end
                ST_TAKE: begin
                    if (hs_beat) begin
                        beat_q <= dat_tdata;
                        last_q <= dat_tlast;
                    end
                end
                ST_STORE: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + LEN_W'(BYTES_PER_BEAT);
                        if (last_q) begin
                            eof_q <= 1'b1;
                            wi_q  <= '0;
                        end
                    end
                end
                ST_APPEND: begin
                    if (mem_ack) wi_q <= wi_q + 1'b1;
                end
                ST_CLOSE: begin
                    if (mem_ack) begin
                        open_q <= !eof_q;
                        done_q <= eof_q;
                        wi_q   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        app_sel = '0;
        for (int i = 0; i < APP_WORDS; i++) begin
            if (wi_q == IDX_W'(i)) app_sel = app_w[i];
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        dat_tready = 1'b0;
        set_halt   = 1'b0;
        set_idle   = 1'b0;
        adv        = 1'b0;
        unique case (st_q)
            ST_WAIT: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr_o + ADDR_W'({wi_q, 2'b00});
            end
            ST_CHECK: begin
                set_halt = done_cmpl_q;
            end
            ST_TAKE: begin
                dat_tready = run_i && !halted_o && !idle_o;
            end
            ST_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_q + ADDR_W'(cnt_q);
                mem_wdata = beat_q;
            end
            ST_APPEND: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr_o + ADDR_W'(OFS_APP * 4) + ADDR_W'({wi_q, 2'b00});
                mem_wdata = app_sel;
            end
            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr_o + ADDR_W'(OFS_STAT * 4);
                mem_wdata = pack_status(!open_q, eof_q, cnt_q);
                adv       = mem_ack;
                set_idle  = mem_ack && at_tail;
            end
            default: ;
        endcase
    end

    assign done_o = done_q;

endmodule

// File: rtl/s2mm_sg_checker.sv
module s2mm_sg_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_i,
    input logic              start_i,
    input logic              tail_wr_i,
    input logic              dat_tready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              halted_o,
    input logic              idle_o,
    input logic              done_o
);

    AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        dat_tready |-> (run_i && !halted_o && !idle_o)); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R1

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !start_i) |=> halted_o); // R2

    AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !start_i && !tail_wr_i) |=> idle_o); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

endmodule

bind s2mm_sg_engine s2mm_sg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .start_i    (start_i),
    .tail_wr_i  (tail_wr_i),
    .dat_tready (dat_tready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .halted_o   (halted_o),
    .idle_o     (idle_o),
    .done_o     (done_o)
);

// File: tb/s2mm_sg_engine_tb_top.sv
module s2mm_sg_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int NV = 8;
    localparam int BUF_W = 256;   // word index of first buffer

    typedef struct packed {
        logic [7:0] cap;
        logic [7:0] beats;
        logic [7:0] used;
        logic [7:0] full;
        logic [7:0] last;
        logic       idle;
    } vec_t;

    // capacity bytes, beats, descriptors used, bytes in a full one, bytes in last, idle after
    localparam vec_t VECS [NV] = '{
        '{8'd16, 8'd3,  8'd1, 8'd16, 8'd12, 1'b0},
        '{8'd16, 8'd4,  8'd1, 8'd16, 8'd16, 1'b0},
        '{8'd16, 8'd5,  8'd2, 8'd16, 8'd4,  1'b0},
        '{8'd8,  8'd7,  8'd4, 8'd8,  8'd4,  1'b1},
        '{8'd18, 8'd5,  8'd2, 8'd16, 8'd4,  1'b0},
        '{8'd4,  8'd3,  8'd3, 8'd4,  8'd4,  1'b0},
        '{8'd64, 8'd1,  8'd1, 8'd64, 8'd4,  1'b0},
        '{8'd16, 8'd16, 8'd4, 8'd16, 8'd16, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b1, start_i = 1'b0, tail_wr_i = 1'b0, cur_load_i = 1'b0;
    logic [AW-1:0] cur_ptr_i = '0, tail_ptr_i = 32'h0000_00C0;
    logic dat_tvalid = 1'b0, dat_tlast = 1'b0;
    logic [31:0] dat_tdata = '0;
    logic dat_tready;
    logic ctl_tvalid = 1'b0, ctl_tlast = 1'b0;
    logic [31:0] ctl_tdata = '0;
    logic ctl_tready;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [AW-1:0] cur_ptr_o;
    logic halted_o, idle_o, done_o, ctl_err_o;

    logic [31:0] mem [0:511];
    logic [31:0] app_exp [5];

    int checks = 0, fails = 0, done_cnt = 0, err_cnt = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    s2mm_sg_engine #(.ADDR_W(AW), .APP_WORDS(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .start_i(start_i),
        .tail_wr_i(tail_wr_i), .cur_load_i(cur_load_i), .cur_ptr_i(cur_ptr_i),
        .tail_ptr_i(tail_ptr_i), .dat_tvalid(dat_tvalid), .dat_tready(dat_tready),
        .dat_tdata(dat_tdata), .dat_tlast(dat_tlast), .ctl_tvalid(ctl_tvalid),
        .ctl_tready(ctl_tready), .ctl_tdata(ctl_tdata), .ctl_tlast(ctl_tlast),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cur_ptr_o(cur_ptr_o), .halted_o(halted_o), .idle_o(idle_o),
        .done_o(done_o), .ctl_err_o(ctl_err_o)
    );

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (done_o)    done_cnt++;
        if (ctl_err_o) err_cnt++;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL all requirements: watchdog cycles=%0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int v, input int k);
        return {8'(v), 8'(k), 16'hA5C3};
    endfunction

    task automatic pulse_setup();
        @(negedge clk);
        cur_ptr_i = '0; cur_load_i = 1'b1; tail_wr_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        cur_load_i = 1'b0; tail_wr_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic init_ring(input int cap);
        for (int d = 0; d < 4; d++) begin
            mem[d*16 + 0] = ((d + 1) % 4) * 64;
            mem[d*16 + 1] = 32'h400 + d * 64;
            mem[d*16 + 2] = 32'h0C00_0000 | cap;
            for (int w = 3; w < 16; w++) mem[d*16 + w] = '0;
            for (int w = 0; w < 16; w++) mem[BUF_W + d*16 + w] = '0;
        end
    endtask

    task automatic send_ctl(input int n, input int tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ctl_tvalid = 1'b1; ctl_tdata = {8'(tag), 8'h00, 16'(i)}; ctl_tlast = (i == n - 1);
        end
        @(negedge clk);
        ctl_tvalid = 1'b0; ctl_tlast = 1'b0;
    endtask

    task automatic send_pkt(input int v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            dat_tvalid = 1'b1; dat_tdata = pat(v, k); dat_tlast = (k == n - 1);
            while (!dat_tready) @(negedge clk);
        end
        @(negedge clk);
        dat_tvalid = 1'b0; dat_tlast = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        int t = 0;
        while (done_cnt == prev && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk("R4 one completion pulse", 32'(done_cnt - prev), 32'd1);
    endtask

    task automatic run_vec(input int v, input bit new_ctl);
        int prev;
        vec_t t = VECS[v];
        init_ring(int'(t.cap));
        pulse_setup();
        if (new_ctl) begin
            send_ctl(5, 8'hC0 + v);
            for (int i = 0; i < 5; i++) app_exp[i] = {8'(8'hC0 + v), 8'h00, 16'(i)};
        end
        prev = done_cnt;
        send_pkt(v, int'(t.beats));
        wait_done(prev);
        for (int d = 0; d < 4; d++) begin
            int nb = (d == int'(t.used) - 1) ? int'(t.last) : int'(t.full);
            int base = d * (int'(t.full) / 4);
            if (d < int'(t.used)) begin
                logic [31:0] s = 32'h8000_0000 | nb;
                if (d == 0) s[27] = 1'b1;
                if (d == int'(t.used) - 1) s[26] = 1'b1;
                chk("R6/R3/R4 status word", mem[d*16 + 3], s);
                for (int w = 0; w < nb / 4; w++)
                    chk("R1 buffer data", mem[BUF_W + d*16 + w], pat(v, base + w));
                if (nb / 4 < 16)
                    chk("R1 no write past end", mem[BUF_W + d*16 + nb/4], 32'h0);
                for (int i = 0; i < 5; i++)
                    chk("R5 application word", mem[d*16 + 4 + i],
                        (d == int'(t.used) - 1) ? app_exp[i] : 32'h0);
            end else begin
                chk("R1 unused descriptor untouched", mem[d*16 + 3], 32'h0);
            end
        end
        chk("R7 current pointer", cur_ptr_o, 32'((int'(t.used) % 4) * 64));
        chk("R7 idle at tail", {31'b0, idle_o}, {31'b0, t.idle});
    endtask

    initial begin
        bit seen;
        int e0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 halted after reset", {31'b0, halted_o}, 32'd1);
        chk("R10 idle after reset", {31'b0, idle_o}, 32'd0);
        chk("R10 pointer after reset", cur_ptr_o, 32'd0);
        chk("R10 quiet after reset", {29'b0, mem_req, dat_tready, done_o}, 32'd0);

        for (int v = 0; v < NV; v++) run_vec(v, 1'b1);

        // R9: idle engine offers no ready
        seen = 0;
        @(negedge clk); dat_tvalid = 1'b1; dat_tdata = 32'hDEAD_0001;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dat_tready) seen = 1;
        end
        dat_tvalid = 1'b0;
        chk("R9 not ready while idle", {31'b0, seen}, 32'd0);

        // R8: wrong-length control packets
        e0 = err_cnt;
        send_ctl(3, 8'h55);
        repeat (2) @(negedge clk);
        chk("R8 short control error", 32'(err_cnt - e0), 32'd1);
        send_ctl(6, 8'h66);
        repeat (2) @(negedge clk);
        chk("R8 long control error", 32'(err_cnt - e0), 32'd2);
        run_vec(2, 1'b0);   // app words must still be the previous good set

        // R2: already-complete descriptor halts
        init_ring(16);
        mem[3] = 32'h8000_0000;
        pulse_setup();
        d0 = done_cnt;
        seen = 0;
        @(negedge clk); dat_tvalid = 1'b1; dat_tdata = 32'hDEAD_0002; dat_tlast = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dat_tready) seen = 1;
        end
        dat_tvalid = 1'b0; dat_tlast = 1'b0;
        chk("R2 halted set", {31'b0, halted_o}, 32'd1);
        chk("R2 no beat accepted", {31'b0, seen}, 32'd0);
        chk("R2 buffer untouched", mem[BUF_W], 32'h0);
        chk("R2 status untouched", mem[3], 32'h8000_0000);
        chk("R2 no completion", 32'(done_cnt - d0), 32'd0);
        chk("R2 pointer kept", cur_ptr_o, 32'd0);
        run_vec(0, 1'b1);
        chk("R2 cleared by start", {31'b0, halted_o}, 32'd0);

        // R9: run low blocks data
        init_ring(16);
        run_i = 1'b0;
        pulse_setup();
        seen = 0;
        @(negedge clk); dat_tvalid = 1'b1; dat_tdata = 32'hDEAD_0003;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dat_tready) seen = 1;
        end
        dat_tvalid = 1'b0;
        run_i = 1'b1;
        chk("R9 not ready while stopped", {31'b0, seen}, 32'd0);
        chk("R9 nothing written while stopped", mem[3], 32'h0);

        finished = 1;
        summary();
    end

endmodule